// File: doc/BRIEF.md
# ECC Memory Error Response Controller

This block decides how each DRAM access ends when the single-error-correct, double-error-detect (SEC-DED) check finds a fault. Each access is one word presented for one clock. It carries an access kind, the word and check bits read from DRAM, and, for writes, the host data and byte enables. One clock later the block returns the host acknowledge and the read data. It also returns a DRAM write request carrying freshly encoded check bits. An interrupt line, a machine-check line and a first-error status record report faults.

There is no bus error-abort path, so every host access ends with a normal acknowledge whatever the fault. The response depends on the pairing of access kind and error class:
- A read returns corrected data on a correctable fault and the raw word on an uncorrectable one.
- A partial write is done as read-modify-write, and its write phase is dropped on an uncorrectable fault.
- A burst write reads nothing, so it is never checked.
- Background scrubs never reach the host and never raise machine check.

Software enables the interrupt, the machine check and the scrub writeback. It clears the sticky lines and the status with a one-cycle clear pulse.

Top module: `ecc_err_resp`

## Requirements
- R1: The code word is the data plus HB Hamming bits and one overall parity bit, where HB is the smallest r with 2^r >= DW+r+1.
  - Data bit i sits at the i-th codeword position, counting up from 3 and skipping powers of two. Hamming bit j is the XOR of the data bits whose position has bit j set. The overall parity bit (top check bit) makes the XOR of all data and check bits zero.
  - The syndrome is the recomputed Hamming bits XOR the stored ones, and the parity flag is the XOR of all received bits.
  - A zero syndrome with a clear flag is clean. A set flag is a single-bit error. A nonzero syndrome with a clear flag is a double-bit error.
  - The status syndrome field reports {flag, syndrome}.
- R2: Access kind codes are 0 single read, 1 burst-read beat, 2 single write, 3 burst-write beat and 4 scrub. One cycle after an access with kind 0 to 3, host_ack is high for exactly one cycle, whatever the error class. A scrub never acknowledges.
- R3: On a read, host_rdata one cycle later holds the corrected word when the access is clean or has a single-bit error, and the raw DRAM word when it has a double-bit error.
- R4: On a single write that is clean or has a single-bit error, mem_we pulses. It writes the corrected read word with every byte whose enable is set replaced by the write byte, and mem_wcheck holds the encoding of that merged word.
- R5: On a single write with a double-bit error, mem_we stays low.
- R6: A burst-write beat writes wr_data unchanged with its encoding, and it never reports an error, whatever check bits arrive.
- R7: A scrub writes back the corrected word only on a single-bit error with scrub_wb_en set. A clean scrub, a scrub with a double-bit error, or a scrub with writeback disabled writes nothing.
- R8: err_int goes high one cycle after any error on a checked access while int_en is set, and stays high until err_clr.
- R9: err_mcp goes high one cycle after a double-bit error on a read or single write while mcp_en is set, and stays high until err_clr. A scrub never raises it.
- R10: The first error latches stat_valid, stat_addr, stat_syn and stat_dbl, which hold until err_clr. A later error while they are held leaves them unchanged and sets stat_ovf.
- R11: An error in the same cycle as err_clr is captured as a new first error with stat_ovf clear.
- R12: Each burst-read beat is corrected on its own. Within one burst, err_int is raised once and remains high, and err_mcp is set if any beat had a double-bit error.
- R13: Kind codes 5 to 7 produce no acknowledge, no write and no error report.
- R14: After reset, host_ack, mem_we, err_int, err_mcp, stat_valid and stat_ovf are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| acc_valid | input | 1 | Access presented this cycle |
| acc_type | input | 3 | Access kind code |
| acc_addr | input | AW | Access address |
| mem_rdata | input | DW | Data word read from DRAM |
| mem_rcheck | input | HB+1 | Check bits read from DRAM |
| wr_data | input | DW | Host write data |
| wr_be | input | DW/8 | Host byte enables |
| int_en | input | 1 | Interrupt enable |
| mcp_en | input | 1 | Machine-check enable |
| scrub_wb_en | input | 1 | Scrub writeback enable |
| err_clr | input | 1 | Clears error lines and status |
| host_ack | output | 1 | Normal termination of a host access |
| host_rdata | output | DW | Data returned to the host |
| mem_we | output | 1 | DRAM write request |
| mem_wdata | output | DW | DRAM write data |
| mem_wcheck | output | HB+1 | DRAM write check bits |
| err_int | output | 1 | Sticky interrupt |
| err_mcp | output | 1 | Sticky machine check |
| stat_valid | output | 1 | Error record held |
| stat_ovf | output | 1 | Further error while held |
| stat_dbl | output | 1 | Held error was uncorrectable |
| stat_addr | output | AW | Address of the held error |
| stat_syn | output | HB+1 | {parity flag, syndrome} of the held error |

## Verification
The assertions watch properties that hold on every cycle:
- no acknowledge follows a scrub or an unused code;
- no write follows an uncorrectable fault outside a burst write;
- a scrub writeback requires its enable;
- machine check never rises from a scrub;
- the sticky lines and the status record stay put until cleared.

Only the bench scenarios can show the data-dependent results. These are the corrected or raw read data, the merged write word and its check bits, and the reported syndrome for every single-bit flip position. They also cover first-error capture against overflow, the clear-versus-capture collision, and the per-beat behaviour inside a burst.

// File: rtl/ecc_err_resp.sv
module ecc_err_resp #(
  parameter int DW = 64,
  parameter int AW = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                acc_valid,
  input  logic [2:0]          acc_type,
  input  logic [AW-1:0]       acc_addr,
  input  logic [DW-1:0]       mem_rdata,
  input  logic [hbits(DW):0]  mem_rcheck,
  input  logic [DW-1:0]       wr_data,
  input  logic [DW/8-1:0]     wr_be,
  input  logic                int_en,
  input  logic                mcp_en,
  input  logic                scrub_wb_en,
  input  logic                err_clr,
  output logic                host_ack,
  output logic [DW-1:0]       host_rdata,
  output logic                mem_we,
  output logic [DW-1:0]       mem_wdata,
  output logic [hbits(DW):0]  mem_wcheck,
  output logic                err_int,
  output logic                err_mcp,
  output logic                stat_valid,
  output logic                stat_ovf,
  output logic                stat_dbl,
  output logic [AW-1:0]       stat_addr,
  output logic [hbits(DW):0]  stat_syn
);

  function automatic int hbits(input int n);
    int res;
    res = 0;
    for (int r = 16; r >= 1; r--)
      if ((1 << r) >= n + r + 1) res = r;
    return res;
  endfunction

  localparam int HB = hbits(DW);
  localparam int CW = HB + 1;
  localparam int NP = DW + HB;
  localparam int NB = DW / 8;

  localparam logic [2:0] T_RD  = 3'd0;
  localparam logic [2:0] T_RDB = 3'd1;
  localparam logic [2:0] T_WR  = 3'd2;
  localparam logic [2:0] T_WRB = 3'd3;
  localparam logic [2:0] T_SCR = 3'd4;

  localparam logic [1:0] C_NONE = 2'd0;
  localparam logic [1:0] C_SGL  = 2'd1;
  localparam logic [1:0] C_DBL  = 2'd2;

  function automatic logic [HB-1:0] ham(input logic [DW-1:0] d);
    logic [HB-1:0] c;
    int k;
    c = '0;
    k = 0;
    for (int p = 1; p <= NP; p++) begin
      if ((p & (p - 1)) != 0) begin
        for (int j = 0; j < HB; j++)
          if (((p >> j) & 1) == 1) c[j] = c[j] ^ d[k];
        k++;
      end
    end
    return c;
  endfunction

  function automatic logic [CW-1:0] enc(input logic [DW-1:0] d);
    logic [HB-1:0] h;
    h = ham(d);
    return {^{d, h}, h};
  endfunction

  logic [HB-1:0] syn;
  logic          par;
  logic [1:0]    cls;
  logic [DW-1:0] corr, merged, wd;
  logic          checked, err, we_n, held;

  assign syn = ham(mem_rdata) ^ mem_rcheck[HB-1:0];
  assign par = ^{mem_rdata, mem_rcheck};
  assign cls = par ? C_SGL : (syn != '0) ? C_DBL : C_NONE;

  always_comb begin : correct_b
    int k;
    corr = mem_rdata;
    k = 0;
    for (int p = 1; p <= NP; p++) begin
      if ((p & (p - 1)) != 0) begin
        if (p == int'(syn)) corr[k] = ~corr[k];
        k++;
      end
    end
  end

  always_comb begin
    for (int b = 0; b < NB; b++)
      merged[b*8 +: 8] = wr_be[b] ? wr_data[b*8 +: 8] : corr[b*8 +: 8];
  end

  assign wd = (acc_type == T_WRB) ? wr_data : (acc_type == T_WR) ? merged : corr;

  assign checked = acc_valid && (acc_type == T_RD || acc_type == T_RDB ||
                                 acc_type == T_WR || acc_type == T_SCR);
  assign err  = checked && cls != C_NONE;
  assign held = stat_valid && !err_clr;
  assign we_n = acc_valid && ((acc_type == T_WRB) ||
                              (acc_type == T_WR && cls != C_DBL) ||
                              (acc_type == T_SCR && cls == C_SGL && scrub_wb_en));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      host_ack   <= 1'b0;
      host_rdata <= '0;
      mem_we     <= 1'b0;
      mem_wdata  <= '0;
      mem_wcheck <= '0;
      err_int    <= 1'b0;
      err_mcp    <= 1'b0;
      stat_valid <= 1'b0;
      stat_ovf   <= 1'b0;
      stat_dbl   <= 1'b0;
      stat_addr  <= '0;
      stat_syn   <= '0;
    end else begin
      host_ack <= acc_valid && acc_type <= T_WRB;
      if (acc_valid && acc_type <= T_RDB)
        host_rdata <= (cls == C_DBL) ? mem_rdata : corr;
      mem_we <= we_n;
      if (we_n) begin
        mem_wdata  <= wd;
        mem_wcheck <= enc(wd);
      end
      err_int  <= (err_int && !err_clr) || (err && int_en);
      err_mcp  <= (err_mcp && !err_clr) ||
                  (checked && acc_type != T_SCR && cls == C_DBL && mcp_en);
      stat_ovf <= (stat_ovf && !err_clr) || (err && held);
      if (!held) begin
        stat_valid <= err;
        if (err) begin
          stat_addr <= acc_addr;
          stat_syn  <= {par, syn};
          stat_dbl  <= (cls == C_DBL);
        end
      end
    end
  end

  // R2
  ack_kind_chk: assert property (@(posedge clk) disable iff (!rst_n)
    host_ack |-> $past(acc_valid && acc_type <= T_WRB));

  // R5
  no_dbl_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> $past(acc_valid && (acc_type == T_WRB || cls != C_DBL)));

  // R7
  scrub_wb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we && $past(acc_type == T_SCR)) |-> $past(scrub_wb_en));

  // R8
  int_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (err_int && !err_clr) |=> err_int);

  // R9
  scrub_no_mcp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_mcp) |-> $past(acc_valid && acc_type != T_SCR && mcp_en));

  // R10
  ovf_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stat_ovf |-> stat_valid);

  // R10
  stat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_valid && !err_clr) |=> ($stable(stat_addr) && $stable(stat_syn)));

  // R13
  unused_kind_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && acc_type > T_SCR) |=> (!host_ack && !mem_we));

endmodule

// File: tb/ecc_err_resp_bench.sv
`timescale 1ns/1ps
module ecc_err_resp_bench;
  localparam int DW = 16;
  localparam int AW = 8;
  localparam int CW = 6;
  localparam int FW = DW + CW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic acc_valid = 1'b0;
  logic [2:0] acc_type = '0;
  logic [AW-1:0] acc_addr = '0;
  logic [DW-1:0] mem_rdata = '0;
  logic [CW-1:0] mem_rcheck = '0;
  logic [DW-1:0] wr_data = '0;
  logic [1:0] wr_be = '0;
  logic int_en = 1'b0, mcp_en = 1'b0, scrub_wb_en = 1'b0, err_clr = 1'b0;
  logic host_ack, mem_we, err_int, err_mcp, stat_valid, stat_ovf, stat_dbl;
  logic [DW-1:0] host_rdata, mem_wdata;
  logic [CW-1:0] mem_wcheck, stat_syn;
  logic [AW-1:0] stat_addr;

  int nchk = 0, nfail = 0;

  always #2.5 clk = ~clk;

  ecc_err_resp #(.DW(DW), .AW(AW)) u_ecc_err_resp (
    .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_type(acc_type),
    .acc_addr(acc_addr), .mem_rdata(mem_rdata), .mem_rcheck(mem_rcheck),
    .wr_data(wr_data), .wr_be(wr_be), .int_en(int_en), .mcp_en(mcp_en),
    .scrub_wb_en(scrub_wb_en), .err_clr(err_clr), .host_ack(host_ack),
    .host_rdata(host_rdata), .mem_we(mem_we), .mem_wdata(mem_wdata),
    .mem_wcheck(mem_wcheck), .err_int(err_int), .err_mcp(err_mcp),
    .stat_valid(stat_valid), .stat_ovf(stat_ovf), .stat_dbl(stat_dbl),
    .stat_addr(stat_addr), .stat_syn(stat_syn));

  function automatic int bpos(input int i);
    int k;
    k = 0;
    for (int p = 3; p < 64; p++)
      if ($countones(p) > 1) begin
        if (k == i) return p;
        k++;
      end
    return 0;
  endfunction

  function automatic logic [CW-1:0] benc(input logic [DW-1:0] d);
    logic [4:0] h;
    h = '0;
    for (int i = 0; i < DW; i++)
      if (d[i]) h = h ^ 5'(bpos(i));
    return {^{d, h}, h};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic clear_all();
    @(negedge clk) err_clr = 1'b1;
    @(negedge clk) err_clr = 1'b0;
  endtask

  task automatic present(input logic [2:0] t, input logic [AW-1:0] a, input logic [DW-1:0] d,
                         input logic [FW-1:0] mask, input logic [DW-1:0] w, input logic [1:0] be);
    logic [FW-1:0] cw;
    cw = {benc(d), d} ^ mask;
    acc_valid = 1'b1; acc_type = t; acc_addr = a;
    mem_rdata = cw[DW-1:0]; mem_rcheck = cw[FW-1:DW];
    wr_data = w; wr_be = be;
  endtask

  task automatic run_one(input logic [2:0] t, input logic [DW-1:0] d, input int b1, input int b2,
                         input logic [2:0] en, input logic [AW-1:0] a,
                         input logic [DW-1:0] w, input logic [1:0] be);
    logic [FW-1:0] mask;
    int ne;
    logic ck, expwe;
    logic [DW-1:0] expwd, mrg;
    logic [4:0] s;
    mask = '0;
    if (b1 >= 0) mask[b1] = 1'b1;
    if (b2 >= 0) mask[b2] = 1'b1;
    ne = $countones(mask);
    ck = (t == 0 || t == 1 || t == 2 || t == 4);
    for (int b = 0; b < 2; b++) mrg[b*8 +: 8] = be[b] ? w[b*8 +: 8] : d[b*8 +: 8];
    clear_all();
    {int_en, mcp_en, scrub_wb_en} = en;
    present(t, a, d, mask, w, be);
    @(negedge clk) acc_valid = 1'b0;
    chk("R2 ack", 32'(host_ack), 32'(t <= 3));
    if (t <= 1) chk("R3 read data", 32'(host_rdata), 32'(ne == 2 ? d ^ mask[DW-1:0] : d));
    expwe = (t == 3) || (t == 2 && ne < 2) || (t == 4 && ne == 1 && en[0]);
    expwd = (t == 3) ? w : (t == 2) ? mrg : d;
    chk(t == 2 ? (ne == 2 ? "R5 write dropped" : "R4 rmw write") :
        t == 3 ? "R6 burst write" : t == 4 ? "R7 scrub write" : "R13 no write",
        32'(mem_we), 32'(expwe));
    if (expwe) begin
      chk("R4 write data", 32'(mem_wdata), 32'(expwd));
      chk("R4 write check", 32'(mem_wcheck), 32'(benc(expwd)));
    end
    chk("R8 interrupt", 32'(err_int), 32'(ck && ne > 0 && en[2]));
    chk("R9 machine check", 32'(err_mcp), 32'(t <= 2 && ne == 2 && en[1]));
    chk("R10 status valid", 32'(stat_valid), 32'(ck && ne > 0));
    if (ck && ne > 0) begin
      chk("R10 status addr", 32'(stat_addr), 32'(a));
      chk("R1 double flag", 32'(stat_dbl), 32'(ne == 2));
      if (ne == 1) begin
        s = (b1 < DW) ? 5'(bpos(b1)) : (b1 < FW - 1) ? 5'(1 << (b1 - DW)) : 5'd0;
        chk("R1 syndrome", 32'(stat_syn), 32'({1'b1, s}));
      end else chk("R1 double parity flag", 32'(stat_syn[5]), 32'(0));
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nfail++; nchk++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R14
    chk("R14 ack reset", 32'(host_ack), 0);
    chk("R14 we reset", 32'(mem_we), 0);
    chk("R14 int/mcp reset", 32'({err_int, err_mcp}), 0);
    chk("R14 status reset", 32'({stat_valid, stat_ovf}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R14 after release", 32'({host_ack, mem_we, err_int, err_mcp, stat_valid, stat_ovf}), 0);

    for (int t = 0; t <= 5; t++)
      for (int b = -1; b < FW; b++)
        for (int e = 0; e < 8; e++) begin
          logic [DW-1:0] d, w;
          d = 16'(b * 16'h9E37 + t * 16'h1234 + e * 16'h0F1D + 16'hA5C3);
          w = 16'(d * 16'h3B + 16'h5A17);
          run_one(3'(t), d, b, -1, 3'(e), 8'(b + 40), w, 2'(b + e));
          if (b >= 0)
            run_one(3'(t), ~d, b, (b + 7) % FW, 3'(e), 8'(b + 90), w, 2'(b));
        end

    // R10 first error held, second sets overflow
    clear_all();
    {int_en, mcp_en, scrub_wb_en} = 3'b110;
    present(3'd0, 8'h11, 16'h1234, 22'h1 << 3, '0, '0);
    @(negedge clk) present(3'd0, 8'h22, 16'h5678, (22'h1 << 2) | (22'h1 << 9), '0, '0);
    @(negedge clk) acc_valid = 1'b0;
    chk("R10 first addr held", 32'(stat_addr), 32'h11);
    chk("R10 overflow set", 32'(stat_ovf), 1);
    chk("R10 first class held", 32'(stat_dbl), 0);
    chk("R9 mcp after second", 32'(err_mcp), 1);
    // R11 clear collides with new error
    err_clr = 1'b1;
    present(3'd2, 8'h33, 16'h9999, 22'h1 << 20, 16'h0, 2'b00);
    @(negedge clk) begin acc_valid = 1'b0; err_clr = 1'b0; end
    chk("R11 fresh capture addr", 32'(stat_addr), 32'h33);
    chk("R11 overflow cleared", 32'(stat_ovf), 0);
    chk("R11 valid", 32'(stat_valid), 1);
    chk("R11 mcp cleared", 32'(err_mcp), 0);
    chk("R11 int reraised", 32'(err_int), 1);

    // R12 four-beat burst read
    clear_all();
    {int_en, mcp_en, scrub_wb_en} = 3'b110;
    present(3'd1, 8'h40, 16'hC0DE, '0, '0, '0);
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      case (i)
        0: chk("R12 beat0 data", 32'(host_rdata), 32'hC0DE);
        1: chk("R12 beat1 corrected", 32'(host_rdata), 32'hBEEF);
        2: chk("R12 beat2 raw", 32'(host_rdata), 32'(16'hF00D ^ 16'h0011));
        default: chk("R12 beat3 data", 32'(host_rdata), 32'h1357);
      endcase
      if (i == 0) chk("R12 no int on clean beat", 32'(err_int), 0);
      if (i == 1) chk("R12 int on first faulty beat", 32'(err_int), 1);
      case (i)
        0: present(3'd1, 8'h41, 16'hBEEF, 22'h1 << 7, '0, '0);
        1: present(3'd1, 8'h42, 16'hF00D, 22'h11, '0, '0);
        2: present(3'd1, 8'h43, 16'h1357, '0, '0, '0);
        default: acc_valid = 1'b0;
      endcase
    end
    chk("R12 int held", 32'(err_int), 1);
    chk("R12 mcp from beat2", 32'(err_mcp), 1);
    chk("R12 first beat address", 32'(stat_addr), 32'h41);

    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end
endmodule